// File: doc/BRIEF.md
# Fractional Average-Frequency Clock Divider

This block derives a slower clock from a fast, fixed source clock (800 MHz in the target system) by dividing it by a programmable fixed-point ratio. When the ratio is a whole number every output period has the same length. When it carries a fraction, a phase accumulator sums the fractional part once per output period. Each carry out of the accumulator stretches that period by one source cycle, so periods of two neighbouring integer lengths are mixed. The requested frequency is then met on average, at the cost of one source cycle of period jitter.

Software writes the divisor through a simple write port. The value waits in a pending register and is picked up only at the next output period boundary, so a period that is already running is never cut short. The block gives two outputs: a one-cycle enable pulse at the start of each output period, and a derived clock that is high for the first half of each period. Lowering the enable forces both outputs low. Raising it again starts a fresh period with the accumulator cleared.

Top module: `fracdiv_clkgen`

## Requirements
- R1: After reset, and from the first source cycle after `en_i` has been sampled low, `tick_o` and `clk_o` are both 0 and stay 0 while `en_i` stays low.
- R2: One source cycle after `en_i` is first sampled high, `tick_o` and `clk_o` are both 1, and the accumulator starts from zero, so the first period lasts exactly the integer part.
- R3: The divisor word places the integer part I in bits [23:16] and the fractional part F in bits [15:0]. Each period adds F to a 16-bit accumulator, and the period lasts I+1 source cycles when that addition carries out, otherwise I cycles. `tick_o` pulses once, in the first cycle of each period.
- R4: Over the first n complete periods after enabling, the total length is n*I + floor(n*F/65536) source cycles.
- R5: With F = 0, every period lasts exactly I cycles.
- R6: `clk_o` is high in the first floor(I/2) cycles of each period, starting in the `tick_o` cycle, and low for the rest of the period.
- R7: A divisor written during a period does not change that period's length or high time. It applies from the next period onward.
- R8: A write whose integer part is below 2 is ignored, and the previous divisor stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Divisor write strobe |
| cfg_div_i | input | 24 | Divisor: integer bits [23:16], fraction bits [15:0] |
| en_i | input | 1 | Output enable |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |
| clk_o | output | 1 | Divided clock, high for the first half of each period |

## Verification
The enable reaches the outputs after one source edge: the first tick and the high phase appear one cycle after `en_i` is sampled high, and the outputs drop one cycle after it is sampled low. The bench samples on the falling edge and checks each of these in the cycle that follows the change. A divisor write lands in the pending register at the next edge but changes nothing until the next period boundary. The bench therefore issues writes just after a tick and expects the new length only from the following tick onward. Each period's length and high time are measured tick to tick against an accumulator kept in the bench.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

   // Output stage variants
   typedef enum int unsigned {
      OUT_PULSE  = 0,   // clk_o mirrors the period tick
      OUT_SQUARE = 1    // clk_o high for the first half of the period
   } out_mode_e;

   // Smallest integer ratio the divider accepts
   localparam int unsigned MIN_INT_DIV = 2;

endpackage

// File: rtl/fracdiv_cfg_reg.sv
module fracdiv_cfg_reg #(
   parameter int unsigned INT_W  = 8,
   parameter int unsigned FRAC_W = 16,
   parameter logic [INT_W+FRAC_W-1:0] RST_DIV = {8'd4, 16'd0}
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [INT_W+FRAC_W-1:0] div_i,
   output logic [INT_W-1:0]        pend_int_o,
   output logic [FRAC_W-1:0]       pend_frac_o
);
   localparam int unsigned DIV_W = INT_W + FRAC_W;

   logic [DIV_W-1:0] pend_q;
   logic             wr_ok;

   assign wr_ok = we_i && (div_i[DIV_W-1:FRAC_W] >= INT_W'(fracdiv_pkg::MIN_INT_DIV));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= RST_DIV;
      end else if (wr_ok) begin
         pend_q <= div_i;
      end
   end

   assign pend_int_o  = pend_q[DIV_W-1:FRAC_W];
   assign pend_frac_o = pend_q[FRAC_W-1:0];

   // R8: a write with an integer part below the minimum leaves the pending value alone
   assert_reject_low_int_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && (div_i[DIV_W-1:FRAC_W] < INT_W'(fracdiv_pkg::MIN_INT_DIV)))
      |=> $stable(pend_q));

endmodule

// File: rtl/fracdiv_phase_acc.sv
module fracdiv_phase_acc #(
   parameter int unsigned FRAC_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic              fresh_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              ext_o
);
   logic [FRAC_W-1:0] acc_q;
   logic              ext_q;
   logic [FRAC_W:0]   sum;

   assign sum = {1'b0, (fresh_i ? '0 : acc_q)} + {1'b0, frac_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
         ext_q <= 1'b0;
      end else if (clr_i) begin
         acc_q <= '0;
         ext_q <= 1'b0;
      end else if (load_i) begin
         acc_q <= sum[FRAC_W-1:0];
         ext_q <= sum[FRAC_W];
      end
   end

   assign ext_o = ext_q;

   // R5: a zero fraction never stretches a period
   assert_no_stretch_zero_frac_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !clr_i && (frac_i == '0)) |=> !ext_o);

endmodule

// File: rtl/fracdiv_period_cnt.sv
module fracdiv_period_cnt #(
   parameter int unsigned INT_W = 8,
   parameter fracdiv_pkg::out_mode_e OUT_MODE = fracdiv_pkg::OUT_SQUARE
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [INT_W-1:0] pend_int_i,
   input  logic             ext_i,
   output logic             load_o,
   output logic             fresh_o,
   output logic             tick_o,
   output logic             clk_o
);
   localparam int unsigned LEN_W = INT_W + 1;

   logic             run_q;
   logic             tick_q;
   logic [LEN_W-1:0] cnt_q;
   logic [INT_W-1:0] act_int_q;
   logic [LEN_W-1:0] len;
   logic             last;

   assign len     = {1'b0, act_int_q} + LEN_W'(ext_i);
   assign last    = run_q && (cnt_q == (len - LEN_W'(1)));
   assign load_o  = en_i && (!run_q || last);
   assign fresh_o = en_i && !run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q     <= 1'b0;
         tick_q    <= 1'b0;
         cnt_q     <= '0;
         act_int_q <= '0;
      end else if (!en_i) begin
         run_q     <= 1'b0;
         tick_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (load_o) begin
         run_q     <= 1'b1;
         tick_q    <= 1'b1;
         cnt_q     <= '0;
         act_int_q <= pend_int_i;
      end else begin
         tick_q    <= 1'b0;
         cnt_q     <= cnt_q + LEN_W'(1);
      end
   end

   assign tick_o = tick_q;

   generate
      if (OUT_MODE == fracdiv_pkg::OUT_SQUARE) begin : g_square
         logic             clk_q;
         logic [LEN_W-1:0] hi_len;
         assign hi_len = {1'b0, act_int_q} >> 1;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               clk_q <= 1'b0;
            end else if (!en_i) begin
               clk_q <= 1'b0;
            end else if (load_o) begin
               clk_q <= 1'b1;
            end else begin
               clk_q <= (cnt_q + LEN_W'(1)) < hi_len;
            end
         end
         assign clk_o = clk_q;

         // R6: every period opens in its high phase
         assert_tick_opens_high_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick_o |-> clk_o);
      end else begin : g_pulse
         assign clk_o = tick_q;
      end
   endgenerate

   // R1: outputs are low one cycle after the enable was low
   assert_held_low_when_off_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i) |-> (!tick_o && !clk_o));

   // R2: the period after a fresh start is never stretched
   assert_first_period_whole_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_q) |-> !ext_i);

   // R3: the count never passes the current period length
   assert_cnt_in_range_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> (cnt_q < len));

   // R7: the active ratio only changes at a period boundary
   assert_hold_ratio_mid_period_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && run_q && !last) |=> $stable(act_int_q));

endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen #(
   parameter int unsigned INT_W  = 8,
   parameter int unsigned FRAC_W = 16,
   parameter logic [INT_W+FRAC_W-1:0] RST_DIV = {8'd4, 16'd0},
   parameter fracdiv_pkg::out_mode_e OUT_MODE = fracdiv_pkg::OUT_SQUARE
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cfg_we_i,
   input  logic [INT_W+FRAC_W-1:0] cfg_div_i,
   input  logic                    en_i,
   output logic                    tick_o,
   output logic                    clk_o
);
   localparam int unsigned DIV_W = INT_W + FRAC_W;

   generate
      if (INT_W < 2) begin : g_bad_int_w
         $error("fracdiv_clkgen: INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac_w
         $error("fracdiv_clkgen: FRAC_W must be at least 1");
      end
      if (RST_DIV[DIV_W-1:FRAC_W] < INT_W'(fracdiv_pkg::MIN_INT_DIV)) begin : g_bad_rst
         $error("fracdiv_clkgen: RST_DIV integer part below minimum");
      end
   endgenerate

   logic [INT_W-1:0]  pend_int;
   logic [FRAC_W-1:0] pend_frac;
   logic              load;
   logic              fresh;
   logic              ext;

   fracdiv_cfg_reg #(
      .INT_W   (INT_W),
      .FRAC_W  (FRAC_W),
      .RST_DIV (RST_DIV)
   ) cfg_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (cfg_we_i),
      .div_i       (cfg_div_i),
      .pend_int_o  (pend_int),
      .pend_frac_o (pend_frac)
   );

   fracdiv_phase_acc #(
      .FRAC_W (FRAC_W)
   ) acc_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (!en_i),
      .load_i  (load),
      .fresh_i (fresh),
      .frac_i  (pend_frac),
      .ext_o   (ext)
   );

   fracdiv_period_cnt #(
      .INT_W    (INT_W),
      .OUT_MODE (OUT_MODE)
   ) cnt_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .pend_int_i (pend_int),
      .ext_i      (ext),
      .load_o     (load),
      .fresh_o    (fresh),
      .tick_o     (tick_o),
      .clk_o      (clk_o)
   );

endmodule

// File: tb/fracdiv_clkgen_tb.sv
module fracdiv_clkgen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [23:0] cfg_div = '0;
   logic        en = 1'b0;
   logic        tick;
   logic        clk_out;

   int n_chk = 0;
   int n_bad = 0;

   logic [23:0] pend_b = {8'd4, 16'd0};
   logic [23:0] eff_b;
   logic [15:0] acc_b = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fracdiv_clkgen dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .cfg_we_i  (cfg_we),
      .cfg_div_i (cfg_div),
      .en_i      (en),
      .tick_o    (tick),
      .clk_o     (clk_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Measures n complete periods tick to tick; optional write just after the first tick
   task automatic run_periods(input int n, input bit do_wr, input logic [23:0] wv,
                              input string req, output int total);
      int seen = 0;
      int cyc = 0;
      int hi = 0;
      int elen = 0;
      int ehi = 0;
      bit have = 0;
      total = 0;
      while (seen < n + 1) begin
         @(negedge clk);
         if (tick) begin
            if (have) begin
               chk(cyc == elen, {req, " period length"}, cyc, elen);
               chk(hi == ehi, {req, " R6 high time"}, hi, ehi);
               total += cyc;
            end
            begin
               logic [16:0] s;
               eff_b = pend_b;
               s = {1'b0, acc_b} + {1'b0, eff_b[15:0]};
               acc_b = s[15:0];
               elen = int'(eff_b[23:16]) + int'(s[16]);
               ehi = int'(eff_b[23:16]) / 2;
            end
            have = 1;
            cyc = 1;
            hi = int'(clk_out);
            seen++;
            if (do_wr && seen == 1) begin
               cfg_we = 1'b1;
               cfg_div = wv;
               if (wv[23:16] >= 8'd2) pend_b = wv;
            end
         end else begin
            cyc++;
            hi += int'(clk_out);
            cfg_we = 1'b0;
         end
      end
   endtask

   task automatic write_div(input logic [23:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_div = v;
      if (v[23:16] >= 8'd2) pend_b = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic disable_out();
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!tick && !clk_out, "R1 low one cycle after disable", int'(clk_out), 0);
   endtask

   task automatic fresh_enable();
      @(negedge clk);
      en = 1'b1;
      acc_b = '0;
   endtask

   initial begin
      int total;
      void'($urandom(32'd20240401));
      repeat (3) @(negedge clk);
      chk(!tick && !clk_out, "R1 reset state", int'(tick) + int'(clk_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!tick && !clk_out, "R1 idle while disabled", int'(tick) + int'(clk_out), 0);

      // R2: first tick one cycle after enable, opening high
      @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      chk(tick == 1'b1, "R2 tick one cycle after enable", int'(tick), 1);
      chk(clk_out == 1'b1, "R2 clk high one cycle after enable", int'(clk_out), 1);
      disable_out();
      begin
         bit stayed_low = 1;
         repeat (10) begin
            @(negedge clk);
            if (tick || clk_out) stayed_low = 0;
         end
         chk(stayed_low, "R1 stays low while disabled", int'(stayed_low), 1);
      end

      // R5: integer-only default ratio 4
      fresh_enable();
      run_periods(6, 1'b0, '0, "R5 zero fraction", total);
      chk(total == 24, "R5 total of six periods", total, 24);
      disable_out();

      // R4/R3: half fraction, fresh start
      write_div({8'd5, 16'h8000});
      fresh_enable();
      run_periods(8, 1'b0, '0, "R3 half fraction", total);
      chk(total == 8 * 5 + 4, "R4 average of eight periods", total, 44);
      disable_out();

      // R4: third fraction, ratio 3
      write_div({8'd3, 16'h5555});
      fresh_enable();
      run_periods(9, 1'b0, '0, "R3 third fraction", total);
      chk(total == 9 * 3 + ((9 * 32'h5555) >> 16), "R4 average of nine periods",
          total, 9 * 3 + ((9 * 32'h5555) >> 16));
      // R8: invalid writes ignored, period unchanged
      run_periods(4, 1'b1, {8'd1, 16'h1234}, "R8 int 1 ignored", total);
      run_periods(4, 1'b1, {8'd0, 16'h0000}, "R8 int 0 ignored", total);
      // R7: mid-period write, boundary ratio 2
      run_periods(5, 1'b1, {8'd2, 16'h0000}, "R7 switch to 2", total);
      run_periods(5, 1'b1, {8'd7, 16'hC000}, "R7 switch to 7.75", total);
      disable_out();

      // Random ratios, each written mid-run
      fresh_enable();
      for (int r = 0; r < 8; r++) begin
         logic [23:0] v;
         v = {8'(2 + ($urandom % 11)), 16'($urandom)};
         run_periods(10, 1'b1, v, "R3 random ratio", total);
      end
      disable_out();

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule